// File: doc/BRIEF.md
# Binary Correlation Matrix Memory

This block is a small binary associative memory. A bit matrix of `ROWS` rows by `COLS` columns holds learned associations: each row stands for one bit of an input (key) vector, and each column acts as one neuron, which is one bit of the output (record) vector. Training folds a key/record pair into the matrix. Recall takes a query key and counts, for every column, how many of the rows selected by the query hold a 1 in that column. That count is the column's match score.

The scores then pass through one of two threshold stages, chosen per recall. The absolute mode sets a column's result bit when its score reaches a given level. The top-L mode sets the bits of the L best-scoring columns, and breaks ties in favour of the lower column index. A clear command sweeps the matrix back to zero. The block refuses other commands while it sweeps or recalls.

Commands arrive on a single valid strobe with a 2-bit opcode. The `busy` output tells the user when a strobe will be ignored. The `done` output marks the cycle in which a new result is available.

Top module: `assoc_bitmem`

## Requirements
- R1: A train command (`cmd_op`=0), accepted while not busy, sets matrix bit (r,c) wherever `vec_in[r]` and `vec_out[c]` are both 1. It ORs into the matrix and never clears a bit that is already 1. It completes in the accepting cycle and does not raise `busy`.
- R2: During a recall (`cmd_op`=1, query on `vec_in`), the score of column c equals the number of rows r with `vec_in[r]`=1 and matrix bit (r,c)=1.
- R3: With `thr_mode`=0 (absolute), `result[c]` is 1 exactly when the score of column c is greater than or equal to `thr_level`. A level of 0 therefore sets every bit.
- R4: With `thr_mode`=1 (top-L), exactly min(`top_l`, `COLS`) bits are set. They mark the highest scores, and among equal scores the lower column index wins.
- R5: `done` is a one-cycle pulse. It is high in the cycle that starts ROWS+1 clock edges after the edge that accepts a recall, and `result` takes its new value in that same cycle.
- R6: `busy` is high from the edge that accepts a recall until `done` rises. Any command presented while `busy` is high is ignored: the matrix, the result and the timing are unchanged.
- R7: A clear command (`cmd_op`=2) holds `busy` high for exactly ROWS cycles. After it, every recall scores zero in every column.
- R8: After reset, `busy`, `done` and `result` are 0 and the matrix is empty.
- R9: `result` holds its value from one `done` pulse to the next. Opcode 3 is a no-operation.
- R10: In top-L mode with `top_l`=0, the result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 train, 1 recall, 2 clear, 3 no-op |
| vec_in | input | ROWS | Training key or recall query |
| vec_out | input | COLS | Training record |
| thr_mode | input | 1 | 0 absolute level, 1 top-L |
| thr_level | input | clog2(ROWS+1) | Absolute threshold level |
| top_l | input | clog2(COLS+1) | Number of columns to select in top-L mode |
| busy | output | 1 | Recall or clear in progress; commands ignored |
| done | output | 1 | One-cycle pulse when a recall result is ready |
| result | output | COLS | Thresholded recall vector |

## Verification
The hardest case to reach from the ports is top-L selection when the scores are tied. Random training almost never produces equal scores straddling the L boundary. The bench therefore clears the matrix and trains two hand-chosen pairs, so that columns share a score exactly where the cut falls, and checks which of them are kept. A second hard case is a command that arrives while a recall is running. The stimulus deliberately issues train and clear strobes inside the busy window, then checks the next recall against a model that ignored them.

// File: rtl/assoc_bitmem_pkg.sv
package assoc_bitmem_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SUM  = 2'd1,
    S_THR  = 2'd2,
    S_CLR  = 2'd3
  } bm_state_e;

  localparam logic [1:0] OP_TRAIN  = 2'd0;
  localparam logic [1:0] OP_RECALL = 2'd1;
  localparam logic [1:0] OP_CLEAR  = 2'd2;
endpackage

// File: rtl/cmm_matrix.sv
module cmm_matrix #(
  parameter int ROWS = 16,
  parameter int COLS = 32,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            train_en,
  input  logic [ROWS-1:0] train_key,
  input  logic [COLS-1:0] train_rec,
  input  logic            wipe_en,
  input  logic [RW-1:0]   wipe_idx,
  input  logic [RW-1:0]   rd_idx,
  output logic [COLS-1:0] rd_row
);
  logic [COLS-1:0] mem [ROWS];

  // One storage row per key bit; clear sweeps one row per cycle
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst)
        mem[r] <= '0;
      else if (wipe_en && wipe_idx == RW'(r))
        mem[r] <= '0;
      else if (train_en && train_key[r])
        mem[r] <= mem[r] | train_rec;
    end
  end

  assign rd_row = mem[rd_idx];
endmodule

// File: rtl/cmm_accum.sv
module cmm_accum #(
  parameter int COLS = 32,
  parameter int CW   = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      zero,
  input  logic                      add_en,
  input  logic [COLS-1:0]           row_bits,
  output logic [COLS-1:0][CW-1:0]   cnt
);
  // One saturating-free counter per column: at most ROWS increments per recall
  for (genvar c = 0; c < COLS; c++) begin : g_col
    always_ff @(posedge clk) begin
      if (rst || zero)
        cnt[c] <= '0;
      else if (add_en && row_bits[c])
        cnt[c] <= cnt[c] + CW'(1);
    end
  end
endmodule

// File: rtl/cmm_select.sv
module cmm_select #(
  parameter int COLS = 32,
  parameter int CW   = 5,
  parameter int LW   = 6
) (
  input  logic [COLS-1:0][CW-1:0] cnt,
  input  logic                    mode_top,
  input  logic [CW-1:0]           level,
  input  logic [LW-1:0]           lsel,
  output logic [COLS-1:0]         sel
);
  // Rank of column c = columns strictly ahead of it (higher score, or equal
  // score at a lower index). Ranks are unique, so rank < L picks exactly L.
  for (genvar c = 0; c < COLS; c++) begin : g_sel
    int rank;
    always_comb begin
      rank = 0;
      for (int j = 0; j < COLS; j++) begin
        if ((cnt[j] > cnt[c]) || ((cnt[j] == cnt[c]) && (j < c)))
          rank = rank + 1;
      end
      if (mode_top)
        sel[c] = (rank < int'(lsel));
      else
        sel[c] = (cnt[c] >= level);
    end
  end
endmodule

// File: rtl/assoc_bitmem.sv
module assoc_bitmem
  import assoc_bitmem_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 32,
  localparam int CW = $clog2(ROWS + 1),
  localparam int LW = $clog2(COLS + 1),
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [ROWS-1:0] vec_in,
  input  logic [COLS-1:0] vec_out,
  input  logic            thr_mode,
  input  logic [CW-1:0]   thr_level,
  input  logic [LW-1:0]   top_l,
  output logic            busy,
  output logic            done,
  output logic [COLS-1:0] result
);
  bm_state_e              state;
  logic [RW-1:0]          idx;
  logic [ROWS-1:0]        query_q;
  logic                   mode_q;
  logic [CW-1:0]          level_q;
  logic [LW-1:0]          l_q;
  logic [COLS-1:0]        row_bits;
  logic [COLS-1:0][CW-1:0] cnt;
  logic [COLS-1:0]        sel;
  logic                   accept, acc_train, acc_recall, acc_clear, last_row;

  assign busy       = (state != S_IDLE);
  assign accept     = cmd_valid && !busy;
  assign acc_train  = accept && (cmd_op == OP_TRAIN);
  assign acc_recall = accept && (cmd_op == OP_RECALL);
  assign acc_clear  = accept && (cmd_op == OP_CLEAR);
  assign last_row   = (idx == RW'(ROWS - 1));

  cmm_matrix #(.ROWS(ROWS), .COLS(COLS)) u_matrix (
    .clk       (clk),
    .rst       (rst),
    .train_en  (acc_train),
    .train_key (vec_in),
    .train_rec (vec_out),
    .wipe_en   (state == S_CLR),
    .wipe_idx  (idx),
    .rd_idx    (idx),
    .rd_row    (row_bits)
  );

  cmm_accum #(.COLS(COLS), .CW(CW)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .zero     (acc_recall),
    .add_en   ((state == S_SUM) && query_q[idx]),
    .row_bits (row_bits),
    .cnt      (cnt)
  );

  cmm_select #(.COLS(COLS), .CW(CW), .LW(LW)) u_select (
    .cnt      (cnt),
    .mode_top (mode_q),
    .level    (level_q),
    .lsel     (l_q),
    .sel      (sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      idx     <= '0;
      query_q <= '0;
      mode_q  <= 1'b0;
      level_q <= '0;
      l_q     <= '0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          idx <= '0;
          if (acc_recall) begin
            state   <= S_SUM;
            query_q <= vec_in;
            mode_q  <= thr_mode;
            level_q <= thr_level;
            l_q     <= top_l;
          end else if (acc_clear) begin
            state <= S_CLR;
          end
        end
        S_SUM: begin
          idx <= idx + RW'(1);
          if (last_row) state <= S_THR;
        end
        S_THR: begin
          result <= sel;
          done   <= 1'b1;
          state  <= S_IDLE;
        end
        S_CLR: begin
          idx <= idx + RW'(1);
          if (last_row) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/assoc_bitmem_chk.sv
module assoc_bitmem_chk #(
  parameter int ROWS = 16,
  parameter int COLS = 32,
  localparam int CW = $clog2(ROWS + 1),
  localparam int LW = $clog2(COLS + 1)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cmd_valid,
  input logic [1:0]              cmd_op,
  input logic                    busy,
  input logic                    done,
  input logic [COLS-1:0]         result,
  input logic                    mode_q,
  input logic [CW-1:0]           level_q,
  input logic [LW-1:0]           l_q,
  input logic [COLS-1:0][CW-1:0] cnt
);
  // R5: done never lasts two cycles
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: an accepted recall makes the block busy on the next cycle
  assert_recall_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_op == 2'd1) |=> busy);

  // R7: an accepted clear makes the block busy on the next cycle
  assert_clear_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_op == 2'd2) |=> busy);

  // R9: the result only moves in a done cycle
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  // R4: top-L sets exactly min(L, COLS) bits
  assert_topl_count_R4: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q) |-> ($countones(result) == ((int'(l_q) > COLS) ? COLS : int'(l_q))));

  // R3: absolute mode agrees with the column scores
  for (genvar c = 0; c < COLS; c++) begin : g_w
    assert_level_R3: assert property (@(posedge clk) disable iff (rst)
      (done && !mode_q) |-> (result[c] == (cnt[c] >= level_q)));
  end
endmodule

bind assoc_bitmem assoc_bitmem_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .busy      (busy),
  .done      (done),
  .result    (result),
  .mode_q    (mode_q),
  .level_q   (level_q),
  .l_q       (l_q),
  .cnt       (cnt)
);

// File: tb/assoc_bitmem_bench.sv
`timescale 1ns/1ps
module assoc_bitmem_bench;
  localparam int ROWS = 16;
  localparam int COLS = 32;
  localparam int CW = $clog2(ROWS + 1);
  localparam int LW = $clog2(COLS + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cmd_valid = 1'b0;
  logic [1:0]      cmd_op = 2'd3;
  logic [ROWS-1:0] vec_in = '0;
  logic [COLS-1:0] vec_out = '0;
  logic            thr_mode = 1'b0;
  logic [CW-1:0]   thr_level = '0;
  logic [LW-1:0]   top_l = '0;
  logic            busy, done;
  logic [COLS-1:0] result;

  assoc_bitmem #(.ROWS(ROWS), .COLS(COLS)) u_assoc_bitmem (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .vec_in(vec_in), .vec_out(vec_out), .thr_mode(thr_mode),
    .thr_level(thr_level), .top_l(top_l), .busy(busy), .done(done),
    .result(result)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [COLS-1:0] m_mem [ROWS];
  int              m_left = 0;
  bit              m_is_recall = 0;
  bit              m_done = 0;
  logic [COLS-1:0] m_result = '0;
  logic [COLS-1:0] m_pending = '0;

  function automatic logic [COLS-1:0] calc(input logic [ROWS-1:0] q, input bit top,
                                           input int lvl, input int l);
    int cnt [COLS];
    bit taken [COLS];
    logic [COLS-1:0] res = '0;
    for (int c = 0; c < COLS; c++) begin
      cnt[c] = 0;
      taken[c] = 0;
      for (int r = 0; r < ROWS; r++)
        if (q[r] && m_mem[r][c]) cnt[c]++;
    end
    if (!top) begin
      for (int c = 0; c < COLS; c++) res[c] = (cnt[c] >= lvl);
    end else begin
      for (int k = 0; k < l && k < COLS; k++) begin
        int best = -1;
        for (int c = 0; c < COLS; c++)
          if (!taken[c] && (best < 0 || cnt[c] > cnt[best])) best = c;
        taken[best] = 1;
        res[best] = 1'b1;
      end
    end
    return res;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) m_mem[r] = '0;
      m_left = 0; m_done = 0; m_result = '0;
    end else begin
      m_done = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0 && m_is_recall) begin
          m_done = 1;
          m_result = m_pending;
        end
      end else if (cmd_valid) begin
        case (cmd_op)
          2'd0: for (int r = 0; r < ROWS; r++) if (vec_in[r]) m_mem[r] = m_mem[r] | vec_out;
          2'd1: begin
            m_pending = calc(vec_in, thr_mode, int'(thr_level), int'(top_l));
            m_is_recall = 1; m_left = ROWS + 1;
          end
          2'd2: begin
            for (int r = 0; r < ROWS; r++) m_mem[r] = '0;
            m_is_recall = 0; m_left = ROWS;
          end
          default: ;
        endcase
      end
    end
  end

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(busy == (m_left > 0), "R6 busy", 64'(busy), 64'(m_left > 0));
      chk(done == m_done, "R5 done", 64'(done), 64'(m_done));
      chk(result == m_result, "R3/R4 result", 64'(result), 64'(m_result));
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [1:0] op, input logic [ROWS-1:0] k, input logic [COLS-1:0] v,
                      input bit top, input int lvl, input int l);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; vec_in = k; vec_out = v;
    thr_mode = top; thr_level = CW'(lvl); top_l = LW'(l);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd3;
  endtask

  task automatic wait_done(output int waited);
    waited = 0;
    while (!done && waited < 1000) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic recall(input logic [ROWS-1:0] q, input bit top, input int lvl, input int l,
                        input logic [COLS-1:0] exp, input string req);
    int w;
    send(2'd1, q, '0, top, lvl, l);
    wait_done(w);
    chk(w == ROWS + 1, "R5 latency", 64'(w), 64'(ROWS + 1));
    chk(result == exp, req, 64'(result), 64'(exp));
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int seed = 7;
    int w;
    logic [COLS-1:0] keep;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state and empty matrix
    chk(busy == 0 && done == 0 && result == '0, "R8", {62'd0, busy, done}, 64'd0);
    recall({ROWS{1'b1}}, 0, 1, 0, '0, "R8 empty matrix");

    // R1: OR-in training, existing ones kept
    send(2'd0, 16'h0003, 32'h0000_00F0, 0, 0, 0);
    send(2'd0, 16'h0001, 32'h0000_0F00, 0, 0, 0);
    recall(16'h0001, 0, 1, 0, 32'h0000_0FF0, "R1 row0");
    recall(16'h0002, 0, 1, 0, 32'h0000_00F0, "R1 row1");
    // R2: scores add across selected rows
    recall(16'h0003, 0, 2, 0, 32'h0000_00F0, "R2 two rows");

    // Random training, then absolute levels (R3) and top-L (R4)
    for (int i = 0; i < 12; i++) begin
      logic [ROWS-1:0] k;
      logic [COLS-1:0] v;
      seed = seed * 1103515245 + 12345; k = ROWS'(seed >>> 7) & ROWS'(seed >>> 13);
      seed = seed * 1103515245 + 12345; v = COLS'(seed) & COLS'(seed >>> 3);
      send(2'd0, k, v, 0, 0, 0);
    end
    for (int lvl = 0; lvl <= 4; lvl++)
      recall(16'hA5F3, 0, lvl, 0, calc(16'hA5F3, 0, lvl, 0), "R3 level sweep");
    recall(16'hFFFF, 0, ROWS, 0, calc(16'hFFFF, 0, ROWS, 0), "R3 top level");
    recall(16'hFFFF, 0, 0, 0, {COLS{1'b1}}, "R3 level zero");
    recall(16'h7E3C, 1, 0, 5, calc(16'h7E3C, 1, 0, 5), "R4 L=5");
    recall(16'h7E3C, 1, 0, COLS, {COLS{1'b1}}, "R4 L=COLS");
    recall(16'h7E3C, 1, 0, COLS + 9, {COLS{1'b1}}, "R4 L above COLS");
    recall(16'hFFFF, 1, 0, 0, '0, "R10 L zero");

    // R6: train and clear inside the busy window are ignored
    keep = calc(16'hFFFF, 0, 1, 0);
    send(2'd1, 16'hFFFF, '0, 0, 1, 0);
    send(2'd0, 16'hFFFF, {COLS{1'b1}}, 0, 0, 0);
    send(2'd2, '0, '0, 0, 0, 0);
    wait_done(w);
    chk(result == keep, "R6 during recall", 64'(result), 64'(keep));
    recall(16'hFFFF, 0, 1, 0, keep, "R6 matrix untouched");

    // R9: result holds, no-op opcode does nothing
    send(2'd3, 16'hFFFF, {COLS{1'b1}}, 0, 0, 0);
    repeat (5) @(negedge clk);
    chk(result == keep && !busy, "R9 hold", 64'(result), 64'(keep));
    recall(16'hFFFF, 0, 1, 0, keep, "R9 no-op left matrix");

    // R7: clear sweep length and empty matrix afterwards
    send(2'd2, '0, '0, 0, 0, 0);
    w = 0;
    while (busy && w < 1000) begin @(negedge clk); w++; end
    chk(w == ROWS, "R7 busy length", 64'(w), 64'(ROWS));
    recall({ROWS{1'b1}}, 0, 1, 0, '0, "R7 cleared");

    // R4: ties broken toward the lower column
    send(2'd0, 16'h0001, 32'h0000_00F0, 0, 0, 0);
    send(2'd0, 16'h0002, 32'h0000_00C0, 0, 0, 0);
    recall(16'h0003, 1, 0, 3, 32'h0000_00D0, "R4 tie L=3");
    recall(16'h0003, 1, 0, 1, 32'h0000_0040, "R4 tie L=1");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule